// File: doc/BRIEF.md
# Serial Peripheral Master Frame Sequencer

This block is the sequencing core of a synchronous serial master. It takes data words from a transmit queue through a valid/ready handshake and shifts each one out on a serial data line, most significant bit first. At the same time it shifts in the reply from the receive line and hands each completed reply word to the receive side with a one-cycle valid strobe. Each word is 4 to 16 bits long. The serial clock runs at the system clock divided by an even ratio that is fixed at build time.

Each word is framed by an active-low select line. The select falls half a serial period before the first clock edge. Data changes on the leading clock edge and is sampled on the trailing edge. The select rises one full serial period after the last bit is sampled. If the queue still holds a word when the current one finishes, the next word follows with no gap and the select stays low. A polarity input picks which level the serial clock rests at, and that choice also decides which edge counts as leading. The word length and the polarity are read only while the block is idle.

Top module: `spi_frame_master`

## Requirements
- R1: The length input selects 4 to 16 bits per word. A value below 4 acts as 4 and a value above 16 acts as 16. Bit (length-1) of the transmit word is sent first and bit 0 is sent last.
- R2: While idle, `sclk` rests at the polarity level, `fss_n` is 1, `mosi` is 0 and `busy` is 0.
- R3: A frame starts only when `enable` and `tx_valid` are both high. `tx_ready` is never high while `enable` is low.
- R4: The first leading clock edge of a frame comes CLK_DIV/2 system cycles after `fss_n` falls, and the first data bit appears on `mosi` at that edge.
- R5: `mosi` changes only on leading edges and `miso` is sampled on trailing edges. During a frame, consecutive clock edges are CLK_DIV/2 system cycles apart.
- R6: `fss_n` rises exactly CLK_DIV system cycles after the trailing edge that samples the last bit of the last word.
- R7: If `tx_valid` is high when a word's last bit ends, the next word is accepted and sent with no gap. `fss_n` stays low across the boundary.
- R8: `rx_valid` pulses for one cycle at the sampling edge of each word's last bit. `rx_data` then holds the received word right-aligned, with the unused upper bits at 0.
- R9: With polarity 0 the clock idles low and leading edges rise. With polarity 1 the clock idles high and leading edges fall.
- R10: `busy` is high from the fall of `fss_n` until its rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new frames to start |
| cpol | input | 1 | Serial clock idle level; read only while idle |
| word_len | input | 5 | Bits per word (4..16, clamped); read only while idle |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_ready | output | 1 | Word on tx_data is taken at this clock edge |
| rx_valid | output | 1 | One-cycle strobe: rx_data holds a new word |
| rx_data | output | 16 | Last received word, right-aligned, zero-filled |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock |
| fss_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A slave model in the bench drives random reply words and records what it samples. Frames vary in word count (1 to 3), length and polarity. Single-word frames and back-to-back frames separate the lead and tail timing from the word-to-word continuation. Directed frames at lengths 4 and 16, and at out-of-range length codes, confirm the clamping and the alignment of the first and last bits. A run with enable low and valid high shows that the enable gate really holds off a frame.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LEAD  = 3'd1,
    S_DRIVE = 3'd2,
    S_CAPT  = 3'd3,
    S_TAIL  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
  parameter int DW = 16,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic [LW-1:0] load_len,
  input  logic          advance,
  input  logic          miso,
  output logic          tx_msb,
  output logic          load_msb,
  output logic [DW-1:0] rx_next
);
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic [DW-1:0] aligned;

  assign aligned  = load_word << (LW'(DW) - load_len);
  assign load_msb = aligned[DW-1];
  assign tx_msb   = tx_sh[DW-1];
  assign rx_next  = {rx_sh[DW-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (load) begin
      tx_sh <= aligned;
      rx_sh <= '0;
    end else if (advance) begin
      tx_sh <= {tx_sh[DW-2:0], 1'b0};
      rx_sh <= rx_next;
    end
  end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int DW      = 16,
  parameter int CLK_DIV = 4,
  parameter int MIN_LEN = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic                     cpol,
  input  logic [$clog2(DW+1)-1:0]  word_len,
  input  logic                     tx_valid,
  input  logic [DW-1:0]            tx_data,
  output logic                     tx_ready,
  output logic                     rx_valid,
  output logic [DW-1:0]            rx_data,
  output logic                     busy,
  output logic                     sclk,
  output logic                     fss_n,
  output logic                     mosi,
  input  logic                     miso
);
  import spi_seq_pkg::*;

  localparam int LW   = $clog2(DW + 1);
  localparam int HALF = CLK_DIV / 2;

  seq_state_t    state;
  logic [LW-1:0] len_q;
  logic [LW-1:0] len_eff;
  logic [LW-1:0] bits_left;
  logic          pol_q;
  logic          tick;
  logic          last_bit;
  logic          word_end;
  logic          start;
  logic          chain;
  logic          load;
  logic [LW-1:0] ld_len;
  logic          advance;
  logic          tx_msb;
  logic          load_msb;
  logic [DW-1:0] rx_next;

  always_comb begin
    if (word_len < LW'(MIN_LEN)) begin
      len_eff = LW'(MIN_LEN);
    end else if (word_len > LW'(DW)) begin
      len_eff = LW'(DW);
    end else begin
      len_eff = word_len;
    end
  end

  assign last_bit = (bits_left == '0);
  assign word_end = (state == S_CAPT) && tick && last_bit;
  assign tx_ready = enable && ((state == S_IDLE) || word_end);
  assign start    = (state == S_IDLE) && tx_ready && tx_valid;
  assign chain    = word_end && tx_ready && tx_valid;
  assign load     = start || chain;
  assign ld_len   = (state == S_IDLE) ? len_eff : len_q;
  assign advance  = (state == S_DRIVE) && tick;

  spi_half_timer #(.HALF(HALF)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (state != S_IDLE),
    .tick (tick)
  );

  spi_shift_path #(.DW(DW), .LW(LW)) u_path (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_word (tx_data),
    .load_len  (ld_len),
    .advance   (advance),
    .miso      (miso),
    .tx_msb    (tx_msb),
    .load_msb  (load_msb),
    .rx_next   (rx_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      sclk      <= 1'b0;
      fss_n     <= 1'b1;
      mosi      <= 1'b0;
      busy      <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      len_q     <= LW'(MIN_LEN);
      bits_left <= '0;
      pol_q     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          sclk <= cpol;
          mosi <= 1'b0;
          if (start) begin
            state <= S_LEAD;
            fss_n <= 1'b0;
            busy  <= 1'b1;
            len_q <= len_eff;
            pol_q <= cpol;
          end
        end
        S_LEAD: begin
          if (tick) begin
            state     <= S_DRIVE;
            sclk      <= ~pol_q;
            mosi      <= tx_msb;
            bits_left <= len_q - 1'b1;
          end
        end
        S_DRIVE: begin
          if (tick) begin
            state <= S_CAPT;
            sclk  <= pol_q;
            if (last_bit) begin
              rx_valid <= 1'b1;
              rx_data  <= rx_next;
            end
          end
        end
        S_CAPT: begin
          if (tick) begin
            if (!last_bit) begin
              state     <= S_DRIVE;
              sclk      <= ~pol_q;
              mosi      <= tx_msb;
              bits_left <= bits_left - 1'b1;
            end else if (chain) begin
              state     <= S_DRIVE;
              sclk      <= ~pol_q;
              mosi      <= load_msb;
              bits_left <= len_q - 1'b1;
            end else begin
              state <= S_TAIL;
            end
          end
        end
        S_TAIL: begin
          if (tick) begin
            state <= S_IDLE;
            fss_n <= 1'b1;
            busy  <= 1'b0;
            mosi  <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic tx_valid,
  input logic tx_ready,
  input logic sclk,
  input logic fss_n,
  input logic mosi,
  input logic busy,
  input logic rx_valid
);
  // R2
  idle_mosi_low_chk: assert property (@(posedge clk) disable iff (rst)
    fss_n |-> !mosi);

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fss_n) |-> $past(enable && tx_valid));

  // R3
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> enable);

  // R4
  lead_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fss_n) |-> $stable(sclk));

  // R6
  tail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fss_n) |-> $stable(sclk));

  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  rx_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !fss_n);

  // R10
  busy_frame_chk: assert property (@(posedge clk) disable iff (rst)
    busy != fss_n);
endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .sclk     (sclk),
  .fss_n    (fss_n),
  .mosi     (mosi),
  .busy     (busy),
  .rx_valid (rx_valid)
);

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 6;
  localparam int HALF       = DIV / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        cpol = 1'b0;
  logic [4:0]  word_len = 5'd8;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_ready;
  logic        rx_valid;
  logic [15:0] rx_data;
  logic        busy;
  logic        sclk;
  logic        fss_n;
  logic        mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  spi_frame_master #(.DW(16), .CLK_DIV(DIV), .MIN_LEN(4)) uut (
    .clk(clk), .rst(rst), .enable(enable), .cpol(cpol), .word_len(word_len),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sclk(sclk),
    .fss_n(fss_n), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // frame context shared with the monitor
  int          cur_len = 8;
  bit          cur_pol = 1'b0;
  int          exp_words = 0;
  logic [15:0] tx_w [0:3];
  logic [15:0] sl_w [0:3];
  int          widx = 0;
  int          rx_idx = 0;

  function automatic int eff_len(input int wl);
    if (wl < 4) return 4;
    if (wl > 16) return 16;
    return wl;
  endfunction

  function automatic logic [15:0] lmask(input int len);
    return 16'((32'h1 << len) - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor and slave model, sampled on the falling system edge
  int          cyc = 0;
  logic        p_sclk = 1'b0;
  logic        p_fss = 1'b1;
  int          t_fall = 0;
  int          last_edge = 0;
  int          last_cap = -100;
  bit          first_edge = 1'b0;
  int          bitpos = 0;
  logic [15:0] sl_rx = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_fss && !fss_n) begin
        t_fall = cyc; first_edge = 1'b1; bitpos = 0; sl_rx = '0;
        chk(busy, "R10 busy at select fall", busy, 1);
      end
      if (!fss_n && sclk !== p_sclk) begin
        if (sclk == ~cur_pol) begin
          // leading edge, R9: direction set by polarity
          if (first_edge) chk(cyc - t_fall == HALF, "R4 lead delay", cyc - t_fall, HALF);
          else chk(cyc - last_edge == HALF, "R5 edge spacing", cyc - last_edge, HALF);
          first_edge = 1'b0;
          last_edge = cyc;
          if (widx < 4) miso <= sl_w[widx][cur_len-1-bitpos];
        end else begin
          chk(cyc - last_edge == HALF, "R5 edge spacing trailing", cyc - last_edge, HALF);
          last_edge = cyc;
          sl_rx = {sl_rx[14:0], mosi};
          bitpos++;
          if (bitpos == cur_len) begin
            if (widx < 4)
              chk(sl_rx == (tx_w[widx] & lmask(cur_len)), "R1 serial word", sl_rx, tx_w[widx] & lmask(cur_len));
            widx++; bitpos = 0; sl_rx = '0;
            last_cap = cyc;
          end
        end
      end
      if (rx_valid) begin
        chk(last_cap == cyc, "R8 strobe on last capture", last_cap, cyc);
        if (rx_idx < 4)
          chk(rx_data == (sl_w[rx_idx] & lmask(cur_len)), "R8 rx word", rx_data, sl_w[rx_idx] & lmask(cur_len));
        rx_idx++;
      end
      if (!p_fss && fss_n) begin
        chk(cyc - last_cap == DIV, "R6 tail delay", cyc - last_cap, DIV);
        chk(widx == exp_words, "R7 words in one frame", widx, exp_words);
      end
    end
    p_sclk = sclk;
    p_fss  = fss_n;
  end

  task automatic check_idle(input string tag);
    @(negedge clk);
    chk(sclk == cpol, {"R9 idle clock ", tag}, sclk, cpol);
    chk(fss_n && !mosi && !busy, {"R2 idle lines ", tag}, {fss_n, mosi, busy}, 3'b100);
  endtask

  task automatic run_frame(input int n, input int wl, input bit pol);
    word_len = 5'(wl);
    cpol = pol;
    cur_pol = pol;
    cur_len = eff_len(wl);
    exp_words = n;
    for (int i = 0; i < 4; i++) begin
      tx_w[i] = 16'($urandom);
      sl_w[i] = 16'($urandom);
    end
    widx = 0;
    rx_idx = 0;
    repeat (3) @(posedge clk);
    check_idle("before frame");
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tx_valid = 1'b1;
      tx_data = tx_w[i];
      do @(negedge clk); while (!tx_ready);
      @(posedge clk); #1;
      if (i == n - 1) tx_valid = 1'b0;
    end
    tx_valid = 1'b0;
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
    chk(rx_idx == n, "R8 rx count", rx_idx, n);
    check_idle("after frame");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    check_idle("reset");
    // R3: enable low holds off any frame
    enable = 1'b0;
    tx_valid = 1'b1;
    tx_data = 16'hA5A5;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (!fss_n || tx_ready) seen = 1'b1;
      end
      chk(!seen, "R3 enable gate", seen, 0);
    end
    tx_valid = 1'b0;
    enable = 1'b1;
    // directed corners
    run_frame(1, 4, 1'b0);
    run_frame(1, 16, 1'b0);
    run_frame(1, 2, 1'b1);   // R1 clamp to 4
    run_frame(2, 31, 1'b0);  // R1 clamp to 16
    run_frame(3, 8, 1'b1);   // R7 three words
    // random mix, fixed seed
    void'($urandom(32'd1234));
    for (int f = 0; f < 30; f++) begin
      run_frame(1 + int'($urandom % 3), 4 + int'($urandom % 13), 1'($urandom));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < 150000; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule